// File: doc/BRIEF.md
# I2C Target with Register Bank

This block is an I2C bus target that exposes a bank of byte-wide registers to a bus controller. It samples the clock and data lines from open-drain pads through two-flop synchronisers on a fast system clock and detects bus edges there. It can only pull the data line low and never drives it high. It recognises START, repeated START and STOP at any point, and it answers only to one fixed 7-bit device address.

A write transaction carries a register index in its first data byte. Any later bytes go into consecutive registers. A read is normally set up with a short write that carries only the index, followed by a repeated START and the address with the read bit set. The target then returns consecutive registers for as long as the controller acknowledges. The register pointer stays valid between transactions, so a read that starts without a write phase continues from where the last access stopped. A combinational debug port shows any register at any time.

Top module: `i2c_regbank_target`

## Requirements
- R1: A falling data edge while the clock is high is a START. A rising data edge while the clock is high is a STOP. Both are recognised in any state, including in the middle of a byte. After either one the target releases the data line. A STOP returns the target to idle, and a START makes it expect a new address.
- R2: The address byte holds 7 address bits, MSB first, followed by a direction bit (1 = read, 0 = write). When the address equals DEV_ADDR (default 0x42), the target pulls data low for the whole 9th clock.
- R3: When the address does not match, the target never pulls the data line low until the next START or STOP, and no register changes.
- R4: In a write, the first byte after the address loads the register pointer from its low 4 bits, so an index of 16 or more is masked. The target acknowledges this byte.
- R5: Each later written byte is stored at the pointer and acknowledged, and the pointer then increments modulo 16.
- R6: After an address with the read bit set, the target shifts out the register at the pointer, MSB first, and the pointer then increments modulo 16.
- R7: When the controller acknowledges a read byte, the next register follows. When the controller does not acknowledge, the target releases data and stays silent until START or STOP.
- R8: The data output of the target changes only while the synchronised clock is low, that is, after a falling clock edge.
- R9: While the synchronous active-low reset is asserted, the target goes idle, releases data and clears all registers to 0.
- R10: dbg_data always equals the register selected by dbg_idx.
- R11: The register pointer keeps its value across transactions. A read with no write phase starts at the register after the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | 1 = pull the data pad low, 0 = release it |
| dbg_idx | input | 4 | Register index for the debug port |
| dbg_data | output | 8 | Contents of the register selected by dbg_idx |

## Verification
If the bit counter or the controller state drifts, the target acknowledges in the wrong clock or drives data during a bit that belongs to the controller. This shows on the bus within the same byte. If the pointer is wrong, the wrong byte appears on a read or lands on the debug port, and this is seen at the next acknowledged byte. A missed START or STOP makes the target answer a foreign address or stay silent on its own address, and this shows in the 9th clock of the next address byte.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared types and constants for the I2C register-bank target.
// Assumes byte-wide frames; state encoding is private to the block.
package i2c_tgt_pkg;

    localparam int FRAME_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-stage synchroniser for asynchronous pad inputs.
// Assumes the lines idle high, so every stage resets to 1.
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pad values through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
// Module: edge and bus-condition detector on synchronised SCL/SDA.
// Assumes both inputs are already synchronised to clk and idle high.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, sda_d;

    // Keep the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
// Module: register bank with one write port, one pointer read port and
// one debug read port. Assumes a single write per cycle; reads are combinational.
module i2c_tgt_regs #(
    parameter int NUM_REGS = 16,
    parameter int DW       = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] ptr_idx,
    output logic [DW-1:0]    ptr_data,
    input  logic [IDX_W-1:0] dbg_idx,
    output logic [DW-1:0]    dbg_data
);
    logic [DW-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Hold one register; clear on reset, load when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                bank[g] <= wr_data;
        end
    end

    assign ptr_data = bank[ptr_idx];
    assign dbg_data = bank[dbg_idx];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Module: protocol sequencer for the target. Shifts address and data
// bits in on SCL rise, updates its SDA pull-down only on SCL fall, and
// keeps the auto-incrementing register pointer.
// Assumes one-cycle event strobes from i2c_bus_events.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int IDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  sda_s,
    input  logic                  start_ev,
    input  logic                  stop_ev,
    input  logic [FRAME_BITS-1:0] rd_byte,
    output logic [IDX_W-1:0]      ptr,
    output logic                  wr_en,
    output logic [FRAME_BITS-1:0] wr_data,
    output logic                  sda_low,
    output tgt_state_e            state
);
    localparam logic [3:0] FULL = 4'(FRAME_BITS);
    localparam logic [3:0] LAST = 4'(FRAME_BITS - 1);

    logic [3:0]            cnt;
    logic [FRAME_BITS-1:0] rx_sh, tx_sh;
    logic                  rw_bit, idx_phase, ctl_ack;

    // Store strobe: full data byte that is not the pointer byte.
    assign wr_en   = (state == ST_WR_BYTE) && scl_fall && (cnt == FULL) && !idx_phase;
    assign wr_data = rx_sh;

    // Sequence the transfer; bus conditions override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_bit    <= 1'b0;
            idx_phase <= 1'b0;
            ctl_ack   <= 1'b0;
            ptr       <= '0;
            sda_low   <= 1'b0;
        end else if (start_ev) begin
            state   <= ST_ADDR;
            cnt     <= '0;
            sda_low <= 1'b0;
        end else if (stop_ev) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sda_low <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && cnt < FULL) begin
                        rx_sh <= {rx_sh[FRAME_BITS-2:0], sda_s};
                        cnt   <= cnt + 4'd1;
                    end else if (scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (rx_sh[7:1] == DEV_ADDR) begin
                                state   <= ST_ADDR_ACK;
                                rw_bit  <= rx_sh[0];
                                sda_low <= 1'b1;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else begin
                            if (idx_phase) begin
                                ptr       <= rx_sh[IDX_W-1:0];
                                idx_phase <= 1'b0;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                            state   <= ST_WR_ACK;
                            sda_low <= 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw_bit) begin
                            tx_sh   <= rd_byte;
                            sda_low <= ~rd_byte[FRAME_BITS-1];
                            state   <= ST_RD_BYTE;
                        end else begin
                            sda_low   <= 1'b0;
                            idx_phase <= 1'b1;
                            state     <= ST_WR_BYTE;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        sda_low <= 1'b0;
                        state   <= ST_WR_BYTE;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            sda_low <= 1'b0;
                            ptr     <= ptr + 1'b1;
                            state   <= ST_RD_ACK;
                        end else begin
                            cnt     <= cnt + 4'd1;
                            tx_sh   <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                            sda_low <= ~tx_sh[FRAME_BITS-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ctl_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (ctl_ack) begin
                            tx_sh   <= rd_byte;
                            sda_low <= ~rd_byte[FRAME_BITS-1];
                            state   <= ST_RD_BYTE;
                        end else begin
                            sda_low <= 1'b0;
                            state   <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_regbank_target.sv
// Module: top of the I2C register-bank target. Wires pad synchronisers,
// bus-event detection, the sequencer and the register bank together.
// Assumes clk is at least about 10x the bus clock and open-drain pads.
module i2c_regbank_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h42,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDX_W       = $clog2(NUM_REGS),
    localparam int        DW          = i2c_tgt_pkg::FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_drive_low,
    input  logic [IDX_W-1:0] dbg_idx,
    output logic [DW-1:0]    dbg_data
);
    logic                   scl_s, sda_s;
    logic                   scl_rise, scl_fall, start_ev, stop_ev;
    logic [IDX_W-1:0]       ptr;
    logic                   wr_en;
    logic [DW-1:0]          wr_data, ptr_data;
    i2c_tgt_pkg::tgt_state_e ctrl_state;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
    );

    i2c_bus_events ev_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
        .rd_byte(ptr_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .sda_low(sda_drive_low), .state(ctrl_state)
    );

    i2c_tgt_regs #(.NUM_REGS(NUM_REGS), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(wr_data),
        .ptr_idx(ptr), .ptr_data(ptr_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );
endmodule

// File: rtl/i2c_tgt_checker.sv
// Module: protocol assertions for i2c_regbank_target, attached by bind.
// Assumes the synchronised clock and event strobes of the top module.
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_ev,
    input logic       stop_ev,
    input logic       sda_drive_low,
    input tgt_state_e state
);
    // R8: the pull-down never moves while the clock is high.
    a_r8_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_drive_low));

    // R1: a START leaves the data line released.
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_drive_low);

    // R1: a STOP returns to idle with data released.
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_drive_low));

    // R3 and R7: the ignoring state never pulls data low.
    a_r3_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_drive_low);

    // R9: reset forces idle and release.
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !sda_drive_low));
endmodule

bind i2c_regbank_target i2c_tgt_checker chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_drive_low(sda_drive_low), .state(ctrl_state)
);

// File: tb/i2c_regbank_target_tb_top.sv
// Bench: bit-banged bus controller with a behavioural register model.
// Uses the debug port each idle clock and a silence monitor each clock.
module i2c_regbank_target_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_drive_low;
    logic [3:0] dbg_idx = '0;
    logic [7:0] dbg_data;
    wire        bus_sda = m_sda & ~sda_drive_low;

    int  n_checks = 0, n_fails = 0;
    int  model [16];
    int  mptr = 0;
    bit  cmp_en = 1'b0, silent = 1'b0, done = 1'b0;
    string silent_req = "R3";

    always #2 clk = ~clk;

    i2c_regbank_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_drive_low(sda_drive_low), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R10) and silence monitor (R3/R7).
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("R10", int'(dbg_data), model[dbg_idx]);
            dbg_idx <= dbg_idx + 4'd1;
        end
        if (rst_n && silent) chk(silent_req, int'(sda_drive_low), 0);
    end

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic sweep();
        cmp_en = 1'b1;
        repeat (20) @(negedge clk);
        cmp_en = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hq(); m_scl = 1'b1; hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hq(); m_scl = 1'b1; hq(); m_sda = 1'b1; hq();
    endtask

    task automatic clk_bit(input bit b, output bit s);
        m_sda = b; hq(); m_scl = 1'b1; hq(); s = bus_sda; hq(); m_scl = 1'b0; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(!ack, s);
        m_sda = 1'b1;
    endtask

    // Write transaction: pointer byte then data bytes, model updated per byte.
    task automatic write_txn(input logic [7:0] p, input logic [7:0] d[$]);
        bit ack;
        bus_start();
        send_byte(8'h84, ack); chk("R2 addr ack", ack, 1);
        send_byte(p, ack);     chk("R4 index ack", ack, 1);
        mptr = p % 16;
        foreach (d[i]) begin
            send_byte(d[i], ack); chk("R5 data ack", ack, 1);
            model[mptr] = d[i];
            mptr = (mptr + 1) % 16;
        end
        bus_stop();
        sweep();
    endtask

    // Read n bytes, optionally after a pointer write and repeated START.
    task automatic read_txn(input bit set_ptr, input logic [7:0] p, input int n, input string req);
        bit ack;
        logic [7:0] b;
        bus_start();
        if (set_ptr) begin
            send_byte(8'h84, ack); chk("R2 addr ack", ack, 1);
            send_byte(p, ack);     chk("R4 index ack", ack, 1);
            mptr = p % 16;
            bus_start();
        end
        send_byte(8'h85, ack); chk("R2 read addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            chk(req, int'(b), model[mptr]);
            mptr = (mptr + 1) % 16;
        end
        silent_req = "R7"; silent = 1'b1;
        hq();
        silent = 1'b0;
        bus_stop();
        sweep();
    endtask

    initial begin
        bit ack, s;
        logic [7:0] b;
        foreach (model[i]) model[i] = 0;
        repeat (10) @(negedge clk);
        chk("R9 sda released in reset", int'(sda_drive_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 sda released after reset", int'(sda_drive_low), 0);
        sweep();

        // R4/R5: multi-byte write from index 3.
        write_txn(8'h03, '{8'hA5, 8'h3C, 8'h5A, 8'hC3});
        // R4/R5: index 0x1E is masked to 14 and the pointer wraps to 0.
        write_txn(8'h1E, '{8'h11, 8'h22, 8'h33});
        // R6/R7: read three bytes from index 3, NACK the last.
        read_txn(1'b1, 8'h03, 3, "R6 read data");

        // R3: foreign address is never acknowledged and changes nothing.
        silent_req = "R3"; silent = 1'b1;
        bus_start();
        send_byte(8'h86, ack); chk("R3 foreign addr nack", ack, 0);
        send_byte(8'h00, ack); chk("R3 foreign data nack", ack, 0);
        send_byte(8'h77, ack); chk("R3 foreign data nack", ack, 0);
        bus_stop();
        silent = 1'b0;
        sweep();

        // R11: read without write continues from pointer 6.
        read_txn(1'b0, 8'h00, 2, "R11 pointer kept");
        // R6: read wraps from 15 to 0.
        read_txn(1'b1, 8'h0F, 2, "R6 read wrap");

        // R1: STOP in the middle of a data byte stores nothing.
        bus_start();
        send_byte(8'h84, ack); chk("R2 addr ack", ack, 1);
        send_byte(8'h08, ack); chk("R4 index ack", ack, 1);
        mptr = 8;
        for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
        bus_stop();
        chk("R1 released after stop", int'(sda_drive_low), 0);
        sweep();

        // R1: repeated START mid-byte restarts with a new address.
        bus_start();
        send_byte(8'h84, ack); chk("R2 addr ack", ack, 1);
        send_byte(8'h0B, ack); chk("R4 index ack", ack, 1);
        mptr = 11;
        for (int i = 0; i < 3; i++) clk_bit(1'b0, s);
        bus_start();
        send_byte(8'h85, ack); chk("R1 restart addr ack", ack, 1);
        recv_byte(b, 1'b0);
        chk("R1 read after restart", int'(b), model[mptr]);
        mptr = (mptr + 1) % 16;
        bus_stop();
        sweep();

        // R9: reset mid-read clears the bank and releases data.
        write_txn(8'h02, '{8'hFF});
        bus_start();
        send_byte(8'h85, ack);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 released during reset", int'(sda_drive_low), 0);
        m_scl = 1'b1; m_sda = 1'b1;
        rst_n = 1'b1;
        foreach (model[i]) model[i] = 0;
        mptr = 0;
        repeat (4) @(negedge clk);
        sweep();
        read_txn(1'b0, 8'h00, 1, "R9 pointer cleared");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule